// File: doc/BRIEF.md
# Dual-Mode Character Buffer Write Controller

This block sits between a host write port and a multiplexed character display. It keeps an eight-entry buffer of 6-bit character codes. The host writes it through a 6-bit data bus, an active-low write line, a chip select and a mode input. Three shared pins change role with the mode. In random mode they carry the character address. In sequential mode they become a serial-enable input, an active-low clear input and a buffer-full output. The full output lets several controllers be chained in sequential mode.

The effective strobe is chip select ANDed with the inverted write line. It is brought into the system clock domain through a two-flop synchronizer with edge detection. The strobe going active is the open event. The strobe going inactive is the close event. A separate scan engine reads the buffer through a combinational port. It can blank its drivers while `wr_active_o` is high.

Entry 0 is the leftmost character. In sequential mode, each further entry lands one position to the right.

Inputs must be stable from four clock cycles before each strobe edge until six clock cycles after it. Every effect appears at the ports within five clock cycles of the edge that causes it.

Top module: `disp_wr_ctrl`

## Requirements
- R1: The strobe is `cs_i & ~wr_ni`. Activity on `wr_ni` while `cs_i` is low changes no entry and no output.
- R2: `mode_i` is sampled only at the open event: 1 selects sequential mode, 0 selects random mode. The mode latched at reset is random.
- R3: In random mode, `addr_i` is captured at the open event, and later changes on it are ignored. `data_i` is stored at the captured address at the close event.
- R4: In sequential mode, with `addr_i[0]` (serial enable) high at the open event and the buffer not full, `data_i` is stored at the entry given by the sequence counter. The counter then increments by one.
- R5: In sequential mode, a write with serial enable low, or one that opens while the buffer is full, stores nothing and leaves the counter unchanged.
- R6: While sequential mode is latched, a low on `addr_i[1]` asynchronously sets every entry to 6'b100000 (blank) and the counter to 0, with no clock edge needed. In random mode this has no effect.
- R7: `full_o` is high when sequential mode drives the pin, eight entries have been stored since the last clear or reset, and `shdn_i` is low. It is low at all other times.
- R8: `full_oe_o` falls at the open event of a write that selects random mode. It rises at the close event of a write that selects sequential mode.
- R9: `wr_active_o` is high from the open event to the close event of a write that will store data. It stays low for ignored writes.
- R10: After reset, every entry reads blank, and `full_o`, `full_oe_o` and `wr_active_o` are low.
- R11: `rd_data_o` combinationally shows the entry selected by `rd_addr_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| data_i | input | 6 | Character code from host |
| wr_ni | input | 1 | Active-low write line |
| cs_i | input | 1 | Chip select, active high |
| mode_i | input | 1 | 1 sequential, 0 random |
| addr_i | input | 3 | Random: address. Sequential: bit0 serial enable, bit1 clear_n, bit2 unused |
| shdn_i | input | 1 | Shutdown, forces full flag low |
| full_o | output | 1 | Buffer full flag, shared with address bit 2 |
| full_oe_o | output | 1 | Drive enable for the shared full pin |
| rd_addr_i | input | 3 | Scan engine read address |
| rd_data_o | output | 6 | Scan engine read data |
| wr_active_o | output | 1 | A storing write is in progress |

## Verification
The bench sweeps every random-mode address. It then fills the buffer in sequential mode and checks each entry against a model that tracks the counter and the buffer contents. Several corner cases are targeted, each with the failure it would expose:
- An address that moves after the open event would, in a design sampling it late, land in the wrong entry.
- A ninth write, or one with serial enable low, would overwrite an entry or advance the counter in a design that checks full or enable too late.
- The clear is sampled between clock edges, which catches a design that clears synchronously.
- A clear applied in random mode catches one that ignores the mode.
- Mid-write samples of the pin enable during both mode switches catch a design that flips the pin role at the wrong edge, which would cause a drive conflict on the bus.

// File: rtl/disp_wr_pkg.sv
package disp_wr_pkg;
  typedef enum logic {
    ACC_RAND = 1'b0,
    ACC_SEQ  = 1'b1
  } acc_mode_e;

  function automatic int blank_bit(input int dw);
    return dw - 1;
  endfunction
endpackage

// File: rtl/disp_strobe_sync.sv
module disp_strobe_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strb_i,
  output logic level_o,
  output logic open_o,
  output logic close_o
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= strb_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign level_o = s2_q;
  assign open_o  = s2_q & ~s3_q;
  assign close_o = ~s2_q & s3_q;
endmodule

// File: rtl/disp_wr_seq.sv
module disp_wr_seq
  import disp_wr_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int DW    = 6,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_rst_ni,
  input  logic          level_i,
  input  logic          open_i,
  input  logic          close_i,
  input  logic          mode_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [DW-1:0] wdata_o,
  output logic          seq_o,
  output logic          full_o,
  output logic          oe_o,
  output logic          active_o,
  output logic [CW-1:0] cnt_o
);
  acc_mode_e     mode_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          go_q, oe_q;
  logic [CW-1:0] cnt_q;
  logic          full;

  assign full = (cnt_q == CW'(DEPTH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= ACC_RAND;
      addr_q <= '0;
      data_q <= '0;
      go_q   <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      if (level_i) data_q <= data_i;
      if (open_i) begin
        mode_q <= acc_mode_e'(mode_i);
        addr_q <= addr_i;
        // sequential: addr bit0 is serial enable
        go_q   <= mode_i ? (addr_i[0] & ~full) : 1'b1;
        if (!mode_i) oe_q <= 1'b0;
      end
      if (close_i) begin
        go_q <= 1'b0;
        oe_q <= (mode_q == ACC_SEQ);
      end
    end
  end

  always_ff @(posedge clk_i or negedge clr_rst_ni) begin
    if (!clr_rst_ni) cnt_q <= '0;
    else if (close_i && go_q && mode_q == ACC_SEQ) cnt_q <= cnt_q + 1'b1;
  end

  assign we_o     = close_i & go_q;
  assign waddr_o  = (mode_q == ACC_SEQ) ? cnt_q[AW-1:0] : addr_q;
  assign wdata_o  = data_q;
  assign seq_o    = (mode_q == ACC_SEQ);
  assign full_o   = full;
  assign oe_o     = oe_q;
  assign active_o = go_q;
  assign cnt_o    = cnt_q;
endmodule

// File: rtl/disp_char_buf.sv
module disp_char_buf #(
  parameter int DEPTH  = 8,
  parameter int DW     = 6,
  localparam int AW    = $clog2(DEPTH),
  localparam logic [DW-1:0] BLANK = DW'(1) << (DW - 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem[i] <= BLANK;
      else if (we_i && waddr_i == AW'(i)) mem[i] <= wdata_i;
    end
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/disp_wr_ctrl.sv
module disp_wr_ctrl #(
  parameter int DEPTH = 8,
  parameter int DW    = 6,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] data_i,
  input  logic          wr_ni,
  input  logic          cs_i,
  input  logic          mode_i,
  input  logic [AW-1:0] addr_i,
  input  logic          shdn_i,
  output logic          full_o,
  output logic          full_oe_o,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  output logic          wr_active_o
);
  logic          level, open_evt, close_evt;
  logic          we, seq_mode, full_int, oe;
  logic [AW-1:0] waddr;
  logic [DW-1:0] wdata;
  logic [CW-1:0] seq_cnt;
  logic          clr_rst_n;

  disp_strobe_sync u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .strb_i  (cs_i & ~wr_ni),
    .level_o (level),
    .open_o  (open_evt),
    .close_o (close_evt)
  );

  // clear pin acts only while sequential mode is latched
  assign clr_rst_n = rst_ni & ~(seq_mode & ~addr_i[1]);

  disp_wr_seq #(.DEPTH(DEPTH), .DW(DW)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_rst_ni (clr_rst_n),
    .level_i    (level),
    .open_i     (open_evt),
    .close_i    (close_evt),
    .mode_i     (mode_i),
    .addr_i     (addr_i),
    .data_i     (data_i),
    .we_o       (we),
    .waddr_o    (waddr),
    .wdata_o    (wdata),
    .seq_o      (seq_mode),
    .full_o     (full_int),
    .oe_o       (oe),
    .active_o   (wr_active_o),
    .cnt_o      (seq_cnt)
  );

  disp_char_buf #(.DEPTH(DEPTH), .DW(DW)) u_buf (
    .clk_i   (clk_i),
    .rst_ni  (clr_rst_n),
    .we_i    (we),
    .waddr_i (waddr),
    .wdata_i (wdata),
    .raddr_i (rd_addr_i),
    .rdata_o (rd_data_o)
  );

  assign full_oe_o = oe;
  assign full_o    = oe & full_int & ~shdn_i;
endmodule

// File: rtl/disp_wr_chk.sv
module disp_wr_chk #(
  parameter int DEPTH = 8,
  parameter int DW    = 6,
  parameter int CW    = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          clr_ni,
  input logic          shdn_i,
  input logic          full_o,
  input logic          full_oe_o,
  input logic [DW-1:0] rd_data_o,
  input logic          seq_mode_i,
  input logic [CW-1:0] cnt_i
);
  localparam logic [DW-1:0] BLANK = DW'(1) << (DW - 1);

  // R7
  full_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> (full_oe_o && !shdn_i && cnt_i == CW'(DEPTH)));

  // R6
  clear_blank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_mode_i && !clr_ni) |-> (rd_data_o == BLANK));

  // R8
  oe_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(full_oe_o) |-> seq_mode_i);

  // R8
  oe_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(full_oe_o) |-> !seq_mode_i);

  // R4
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i != $past(cnt_i)) |-> (cnt_i == $past(cnt_i) + 1'b1 || cnt_i == '0));

  // R5
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= CW'(DEPTH));
endmodule

bind disp_wr_ctrl disp_wr_chk #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .clr_ni     (addr_i[1]),
  .shdn_i     (shdn_i),
  .full_o     (full_o),
  .full_oe_o  (full_oe_o),
  .rd_data_o  (rd_data_o),
  .seq_mode_i (seq_mode),
  .cnt_i      (seq_cnt)
);

// File: tb/tb_disp_wr_ctrl.sv
module tb_disp_wr_ctrl;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [5:0] data_i = '0;
  logic       wr_ni = 1'b1, cs_i = 1'b0, mode_i = 1'b0, shdn_i = 1'b0;
  logic [2:0] addr_i = 3'b010;
  logic [2:0] rd_addr_i = '0;
  logic       full_o, full_oe_o, wr_active_o;
  logic [5:0] rd_data_o;

  int total = 0, bad = 0;
  bit done = 0;
  logic [5:0] exp_mem [8];
  int  ecnt = 0;
  bit  eoe = 0;

  always #10 clk = ~clk;

  disp_wr_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni), .data_i(data_i), .wr_ni(wr_ni), .cs_i(cs_i),
    .mode_i(mode_i), .addr_i(addr_i), .shdn_i(shdn_i), .full_o(full_o),
    .full_oe_o(full_oe_o), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .wr_active_o(wr_active_o)
  );

  task automatic chk(input string req, input int act, input int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic chk_mem(input string req);
    for (int i = 0; i < 8; i++) begin
      rd_addr_i = 3'(i);
      #1;
      chk(req, rd_data_o, exp_mem[i]);
    end
  endtask

  task automatic chk_flags(input string req);
    chk({req, " oe"}, full_oe_o, eoe);
    chk({req, " full"}, full_o, int'(eoe && ecnt == 8 && !shdn_i));
    chk({req, " active"}, wr_active_o, 0);
  endtask

  task automatic do_wr(input logic m, input logic [2:0] a, input logic [5:0] d,
                       input logic cs, input logic flip, input string req);
    bit stores, oe_mid;
    stores = cs && (m == 1'b0 || (a[0] && ecnt < 8));
    oe_mid = cs ? (m ? eoe : 1'b0) : eoe;
    @(negedge clk);
    mode_i = m; addr_i = a; data_i = d; cs_i = cs; wr_ni = 1'b0;
    repeat (4) @(negedge clk);
    chk({req, " R9 mid active"}, wr_active_o, int'(stores));
    chk({req, " R8 mid oe"}, full_oe_o, int'(oe_mid));
    if (flip) addr_i = a ^ 3'b101;
    repeat (2) @(negedge clk);
    wr_ni = 1'b1;
    repeat (6) @(negedge clk);
    cs_i = 1'b0;
    if (cs) begin
      if (!m) begin
        exp_mem[a] = d;
        eoe = 0;
      end else begin
        if (a[0] && ecnt < 8) begin
          exp_mem[ecnt] = d;
          ecnt++;
        end
        eoe = 1;
      end
    end
    chk_flags(req);
    chk_mem(req);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) exp_mem[i] = 6'h20;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk_flags("R10 reset");
    chk_mem("R10 R11 reset blank");

    // R3 R11: random sweep, every address
    for (int a = 0; a < 8; a++)
      do_wr(1'b0, 3'(a), 6'((a * 13 + 5) & 63), 1'b1, 1'b0, "R3 sweep");
    // R3: address moved after open event
    do_wr(1'b0, 3'd2, 6'h3f, 1'b1, 1'b1, "R3 late addr");
    // R1: chip select low
    do_wr(1'b0, 3'd5, 6'h11, 1'b0, 1'b0, "R1 cs low");
    // R6: clear pin low in random mode ignored
    @(negedge clk); addr_i = 3'b000;
    repeat (4) @(negedge clk);
    chk_mem("R6 ignored in random");
    addr_i = 3'b010;

    // R2 R8: switch to sequential, first entry lands at 0
    do_wr(1'b1, 3'b011, 6'h01, 1'b1, 1'b0, "R2 R4 first seq");
    // R5: serial enable low
    do_wr(1'b1, 3'b010, 6'h2a, 1'b1, 1'b0, "R5 sen low");
    for (int i = 0; i < 7; i++)
      do_wr(1'b1, 3'b011, 6'(6'h10 + i), 1'b1, 1'b0, "R4 R7 fill");
    chk("R7 full after 8", full_o, 1);
    // R5: write while full
    do_wr(1'b1, 3'b011, 6'h3c, 1'b1, 1'b0, "R5 full write");

    // R7: shutdown gates flag
    @(negedge clk); shdn_i = 1'b1;
    @(negedge clk);
    chk("R7 shutdown full", full_o, 0);
    chk("R7 shutdown oe", full_oe_o, 1);
    shdn_i = 1'b0;
    @(negedge clk);
    chk("R7 shutdown release", full_o, 1);

    // R8: sequential to random
    do_wr(1'b0, 3'd7, 6'h05, 1'b1, 1'b0, "R8 seq to rand");
    // R8: random to sequential, counter still full
    do_wr(1'b1, 3'b010, 6'h06, 1'b1, 1'b0, "R8 rand to seq");
    chk("R8 full valid after close", full_o, 1);

    // R6: asynchronous clear between edges
    @(negedge clk); addr_i = 3'b000;
    #1;
    for (int i = 0; i < 8; i++) exp_mem[i] = 6'h20;
    ecnt = 0;
    chk("R6 async full", full_o, 0);
    chk_mem("R6 async blank");
    addr_i = 3'b010;
    @(negedge clk);
    do_wr(1'b1, 3'b011, 6'h2d, 1'b1, 1'b0, "R4 R6 after clear");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule